// File: doc/BRIEF.md
# Invertible 16-bit Arithmetic and Logic Unit

This unit is the execute stage of a small 16-bit processor. Each cycle it can take two operands, a 5-bit opcode, a 4-bit shift amount and a direction bit. It produces a registered result together with zero, negative and carry flags. The supported operations are OR, ADD, SUB, AND, XOR, pass-immediate and a logical barrel shift. Any other opcode, such as memory, stack or jump, is not executed here. Those opcodes only raise a "not ALU" indication.

Opcode bit 3 acts as a post-inversion bit. When it is set, the final result is bitwise complemented. This gives NOR, NAND, XNOR and negated sums with no extra encodings. Opcode bit 4 selects the operation class, and bits 2..0 select the function within that class. A register move is OR of the source with a zero operand.

Operands are captured only when the input valid is high. The output valid rises one cycle later. When no new input is presented, the output holds its last value.

Top module: `alu_inv16`

## Requirements
- R1: With bit 3 clear, opcode 00001 gives A|B, 00100 gives A&B and 00101 gives A^B. Carry is 0 for these.
- R2: Opcode 00010 gives A+B modulo 2^16. Carry is the carry-out of the 16-bit addition.
- R3: Opcode 00011 gives A-B in two's complement. Carry is the carry-out of A+~B+1, which is 1 exactly when A >= B unsigned.
- R4: Opcode bit 3 set inverts every result bit after the operation, for every executed opcode. Carry is unaffected by the inversion.
- R5: Opcode 0x110 passes operand B (the immediate) to the result. Bit 3 inversion still applies.
- R6: Opcode 1x101 shifts operand A logically by the 4-bit amount. Direction 0 shifts right and 1 shifts left. Vacated bits are zero, an amount of 0 returns A unchanged, and carry is 0.
- R7: The zero flag is 1 exactly when the final (post-inversion) result is 0. The negative flag equals bit 15 of the final result.
- R8: Every other opcode (0x000, 0x111, and 1x with low bits other than 101) sets the not-ALU output. For these, the result is 0 and all flags are 0.
- R9: An input presented with valid high appears on the outputs with output valid high after exactly one rising clock edge. With input valid low, output valid is low after the next edge and the result holds.
- R10: An active-low asynchronous reset clears output valid, result, flags and the not-ALU output at once.
- R11: A move, opcode 00001 with B = 0, returns A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and opcode are valid |
| opcode_i | input | 5 | Class bit 4, invert bit 3, function bits 2..0 |
| op_a_i | input | 16 | Operand A, also the shift source |
| op_b_i | input | 16 | Operand B or immediate |
| shamt_i | input | 4 | Shift amount |
| shl_i | input | 1 | Shift direction, 1 = left |
| out_valid_o | output | 1 | Result registers hold a new result |
| result_o | output | 16 | Registered final result |
| zero_o | output | 1 | Final result is zero |
| neg_o | output | 1 | Bit 15 of final result |
| carry_o | output | 1 | Adder carry-out for ADD and SUB |
| non_alu_o | output | 1 | Opcode was not an ALU operation |

## Verification
The hardest cases are the ones where inversion and the adder interact. In an inverted add that wraps to zero, the result is all ones while carry is still set. An inverted NOR of complementary operands turns an all-ones value into a zero result. The stimulus table reaches these with operand pairs chosen to land exactly on 0000 or FFFF before inversion. It also drives shifts at amounts 0 and 15 in both directions, so that bits cross the full width. The hold behaviour is reached by lowering input valid while changing every operand.

// File: rtl/alu_inv16_pkg.sv
package alu_inv16_pkg;
  localparam int unsigned OPC_W = 5;

  typedef enum logic [2:0] {
    FN_OR, FN_ADD, FN_SUB, FN_AND, FN_XOR, FN_PASS, FN_SHF, FN_NONE
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic invert;
    logic non_alu;
  } ctrl_t;
endpackage

// File: rtl/alu_inv16_decode.sv
module alu_inv16_decode
  import alu_inv16_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o.invert = opcode_i[3];
    unique case ({opcode_i[4], opcode_i[2:0]})
      4'b0001: ctrl_o.fn = FN_OR;
      4'b0010: ctrl_o.fn = FN_ADD;
      4'b0011: ctrl_o.fn = FN_SUB;
      4'b0100: ctrl_o.fn = FN_AND;
      4'b0101: ctrl_o.fn = FN_XOR;
      4'b0110: ctrl_o.fn = FN_PASS;
      4'b1101: ctrl_o.fn = FN_SHF;
      default: ctrl_o.fn = FN_NONE;
    endcase
    ctrl_o.non_alu = (ctrl_o.fn == FN_NONE);
  end
endmodule

// File: rtl/alu_inv16_shift.sv
module alu_inv16_shift #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  output logic [WIDTH-1:0]   data_o
);
  logic [WIDTH-1:0] stg [SHAMT_W+1];
  assign stg[0] = data_i;

  // log-depth barrel: stage k moves by 2**k
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int unsigned DIST = 2 ** k;
    assign stg[k+1] = !amt_i[k] ? stg[k]
                    : left_i    ? (stg[k] << DIST)
                                : (stg[k] >> DIST);
  end

  assign data_o = stg[SHAMT_W];
endmodule

// File: rtl/alu_inv16_exec.sv
module alu_inv16_exec
  import alu_inv16_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SHAMT_W = $clog2(WIDTH)
) (
  input  ctrl_t              ctrl_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  output logic [WIDTH-1:0]   res_o,
  output logic               carry_o
);
  logic             is_sub;
  logic [WIDTH-1:0] b_eff, shf, raw;
  logic [WIDTH:0]   sum;

  alu_inv16_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) i_shift (
    .data_i(a_i), .amt_i(amt_i), .left_i(left_i), .data_o(shf)
  );

  // one adder serves ADD and SUB (A + ~B + 1)
  assign is_sub = (ctrl_i.fn == FN_SUB);
  assign b_eff  = is_sub ? ~b_i : b_i;
  assign sum    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};

  always_comb begin
    unique case (ctrl_i.fn)
      FN_OR:   raw = a_i | b_i;
      FN_ADD,
      FN_SUB:  raw = sum[WIDTH-1:0];
      FN_AND:  raw = a_i & b_i;
      FN_XOR:  raw = a_i ^ b_i;
      FN_PASS: raw = b_i;
      FN_SHF:  raw = shf;
      default: raw = '0;
    endcase
    if (ctrl_i.non_alu)     res_o = '0;
    else if (ctrl_i.invert) res_o = ~raw;
    else                    res_o = raw;
    carry_o = (ctrl_i.fn == FN_ADD || is_sub) ? sum[WIDTH] : 1'b0;
  end
endmodule

// File: rtl/alu_inv16.sv
module alu_inv16
  import alu_inv16_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SHAMT_W = $clog2(WIDTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [WIDTH-1:0]   op_a_i,
  input  logic [WIDTH-1:0]   op_b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               shl_i,
  output logic               out_valid_o,
  output logic [WIDTH-1:0]   result_o,
  output logic               zero_o,
  output logic               neg_o,
  output logic               carry_o,
  output logic               non_alu_o
);
  ctrl_t            ctrl;
  logic [WIDTH-1:0] res_d;
  logic             carry_d;

  alu_inv16_decode i_decode (.opcode_i(opcode_i), .ctrl_o(ctrl));

  alu_inv16_exec #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) i_exec (
    .ctrl_i(ctrl), .a_i(op_a_i), .b_i(op_b_i), .amt_i(shamt_i),
    .left_i(shl_i), .res_o(res_d), .carry_o(carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      zero_o      <= 1'b0;
      neg_o       <= 1'b0;
      carry_o     <= 1'b0;
      non_alu_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o  <= res_d;
        zero_o    <= !ctrl.non_alu && (res_d == '0);
        neg_o     <= res_d[WIDTH-1];
        carry_o   <= carry_d;
        non_alu_o <= ctrl.non_alu;
      end
    end
  end
endmodule

// File: rtl/alu_inv16_chk.sv
module alu_inv16_chk
  import alu_inv16_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SHAMT_W = $clog2(WIDTH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic [OPC_W-1:0]   opcode_i,
  input logic [WIDTH-1:0]   op_a_i,
  input logic [WIDTH-1:0]   op_b_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic               shl_i,
  input logic               out_valid_o,
  input logic [WIDTH-1:0]   result_o,
  input logic               zero_o,
  input logic               neg_o,
  input logic               carry_o,
  input logic               non_alu_o
);
  p_valid_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !non_alu_o) |-> (zero_o == (result_o == '0)));
  p_neg_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !non_alu_o) |-> (neg_o == result_o[WIDTH-1]));
  p_non_alu_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && non_alu_o) |-> (result_o == '0 && !carry_o && !zero_o && !neg_o));
  p_pass_imm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !opcode_i[4] && opcode_i[2:0] == 3'b110) |=>
      (result_o == ($past(opcode_i[3]) ? ~$past(op_b_i) : $past(op_b_i))));
  p_move_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == 5'b00001 && op_b_i == '0) |=> (result_o == $past(op_a_i)));
  p_shift_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == 5'b10101 && shamt_i == '0) |=> (result_o == $past(op_a_i)));
endmodule

bind alu_inv16 alu_inv16_chk #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .opcode_i(opcode_i),
  .op_a_i(op_a_i), .op_b_i(op_b_i), .shamt_i(shamt_i), .shl_i(shl_i),
  .out_valid_o(out_valid_o), .result_o(result_o), .zero_o(zero_o),
  .neg_o(neg_o), .carry_o(carry_o), .non_alu_o(non_alu_o)
);

// File: tb/test_alu_inv16.sv
`timescale 1ns/1ps
module test_alu_inv16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  shamt = '0;
  logic        shl = 1'b0;
  logic        out_valid, zero, neg, carry, non_alu;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_inv16 i_alu_inv16 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .opcode_i(opcode),
    .op_a_i(a), .op_b_i(b), .shamt_i(shamt), .shl_i(shl),
    .out_valid_o(out_valid), .result_o(result), .zero_o(zero),
    .neg_o(neg), .carry_o(carry), .non_alu_o(non_alu)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [3:0]  sh;
    logic        dir;
    logic [15:0] res;
    logic        c;
    logic        na;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 16'hF0F0, 16'h0F0F, 4'd0,  1'b0, 16'hFFFF, 1'b0, 1'b0, 8'd1},  // R1 OR
    '{5'b00100, 16'hF0F0, 16'hFF00, 4'd0,  1'b0, 16'hF000, 1'b0, 1'b0, 8'd1},  // R1 AND
    '{5'b00101, 16'hAAAA, 16'hFFFF, 4'd0,  1'b0, 16'h5555, 1'b0, 1'b0, 8'd1},  // R1 XOR
    '{5'b00010, 16'h0001, 16'h0002, 4'd0,  1'b0, 16'h0003, 1'b0, 1'b0, 8'd2},  // R2
    '{5'b00010, 16'hFFFF, 16'h0001, 4'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 8'd2},  // R2 wrap
    '{5'b00010, 16'h8000, 16'h8000, 4'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 8'd2},  // R2
    '{5'b00011, 16'h0005, 16'h0003, 4'd0,  1'b0, 16'h0002, 1'b1, 1'b0, 8'd3},  // R3
    '{5'b00011, 16'h0003, 16'h0005, 4'd0,  1'b0, 16'hFFFE, 1'b0, 1'b0, 8'd3},  // R3 borrow
    '{5'b00011, 16'h1234, 16'h1234, 4'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 8'd3},  // R3 equal
    '{5'b01001, 16'hF0F0, 16'h0F0F, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b0, 8'd4},  // R4 NOR
    '{5'b01010, 16'hFFFF, 16'h0001, 4'd0,  1'b0, 16'hFFFF, 1'b1, 1'b0, 8'd4},  // R4 inv add
    '{5'b01100, 16'hFFFF, 16'hFFFF, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b0, 8'd4},  // R4 NAND
    '{5'b00110, 16'h1111, 16'hBEEF, 4'd0,  1'b0, 16'hBEEF, 1'b0, 1'b0, 8'd5},  // R5
    '{5'b01110, 16'h1111, 16'h00FF, 4'd0,  1'b0, 16'hFF00, 1'b0, 1'b0, 8'd5},  // R5 inv
    '{5'b10101, 16'h8001, 16'h0000, 4'd4,  1'b0, 16'h0800, 1'b0, 1'b0, 8'd6},  // R6 right
    '{5'b10101, 16'h8001, 16'h0000, 4'd4,  1'b1, 16'h0010, 1'b0, 1'b0, 8'd6},  // R6 left
    '{5'b10101, 16'h1234, 16'hFFFF, 4'd0,  1'b1, 16'h1234, 1'b0, 1'b0, 8'd6},  // R6 amount 0
    '{5'b10101, 16'h0003, 16'h0000, 4'd15, 1'b1, 16'h8000, 1'b0, 1'b0, 8'd6},  // R6 left 15
    '{5'b10101, 16'h8000, 16'h0000, 4'd15, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd6},  // R6 right 15
    '{5'b11101, 16'h00FF, 16'h0000, 4'd4,  1'b0, 16'hFFF0, 1'b0, 1'b0, 8'd4},  // R4 inv shift
    '{5'b00111, 16'h1234, 16'h5678, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 8'd8},  // R8 jump
    '{5'b10001, 16'hFFFF, 16'hFFFF, 4'd3,  1'b0, 16'h0000, 1'b0, 1'b1, 8'd8},  // R8 push
    '{5'b00000, 16'hFFFF, 16'h0001, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 8'd8},  // R8 zero op
    '{5'b11111, 16'hFFFF, 16'h0001, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 8'd8},  // R8
    '{5'b00001, 16'hCAFE, 16'h0000, 4'd0,  1'b0, 16'hCAFE, 1'b0, 1'b0, 8'd11}  // R11 move
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    #1;
    // R10: reset state
    chk(!out_valid && result == 16'h0 && !zero && !neg && !carry && !non_alu, 10,
        "reset state", result, 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      opcode = VECS[i].op; a = VECS[i].a; b = VECS[i].b;
      shamt = VECS[i].sh; shl = VECS[i].dir;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid, 9, $sformatf("vec %0d valid", i), {15'd0, out_valid}, 16'd1);
      chk(result == VECS[i].res, VECS[i].req, $sformatf("vec %0d result", i),
          result, VECS[i].res);
      chk(carry == VECS[i].c, VECS[i].req, $sformatf("vec %0d carry", i),
          {15'd0, carry}, {15'd0, VECS[i].c});
      chk(non_alu == VECS[i].na, 8, $sformatf("vec %0d not-alu", i),
          {15'd0, non_alu}, {15'd0, VECS[i].na});
      // R7: flags from the final result, cleared for non-ALU opcodes
      chk(zero == (!VECS[i].na && VECS[i].res == 16'h0), 7, $sformatf("vec %0d zero", i),
          {15'd0, zero}, {15'd0, (!VECS[i].na && VECS[i].res == 16'h0)});
      chk(neg == VECS[i].res[15], 7, $sformatf("vec %0d neg", i),
          {15'd0, neg}, {15'd0, VECS[i].res[15]});
    end

    // R9: idle input holds result, drops valid
    held = result;
    opcode = 5'b00010; a = 16'h7777; b = 16'h1111; shamt = 4'd2; shl = 1'b1;
    @(negedge clk);
    chk(!out_valid, 9, "valid low when idle", {15'd0, out_valid}, 16'd0);
    chk(result == held, 9, "result held when idle", result, held);

    // R9: back-to-back inputs, each after one edge
    in_valid = 1'b1; opcode = 5'b00010; a = 16'h0010; b = 16'h0020;
    @(negedge clk);
    chk(result == 16'h0030, 9, "back-to-back first", result, 16'h0030);
    opcode = 5'b01101; a = 16'h00F0; b = 16'h0F00;  // XNOR
    @(negedge clk);
    in_valid = 1'b0;
    chk(result == 16'hF00F && neg && !zero, 4, "inverted xor", result, 16'hF00F);

    // R10: asynchronous reset mid-run
    in_valid = 1'b1; opcode = 5'b00001; a = 16'hFFFF; b = 16'h0;
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk(!out_valid && result == 16'h0 && !neg && !carry, 10, "async reset",
        result, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule